// File: doc/BRIEF.md
# Cluster Bus Transaction Sequencer

This block runs one cache controller's transactions on a shared cluster bus. The controller hands over one request at a time through a valid/ready handshake. The request carries an operation code. The sequencer raises a bus request toward an external arbiter and waits for a grant. It then walks through a fixed-length address phase and a data phase whose length depends on the operation and on the slave. When the work is done it pulses a completion strobe that carries the finished operation code. A bus-busy output marks every cycle in which this master owns the bus, so that utilisation can be counted outside.

The address phase combines a one-cycle slot on the bus with three further cycles of decode and initiation time, so it lasts four cycles. Single transfers take one memory access. A block read takes one first access followed by burst beats. A copy-back takes four full memory accesses. An invalidation uses the bus but has no data phase. The slave stretches the data phase through a ready input: a data cycle counts only when that input is high.

The back-pressure rule is simple. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while no transaction is in progress, so a request offered during a transaction stays pending and is not taken.

Top module: `bus_txn_seq`

## Requirements
- R1: During reset and on the cycle after it, `req_ready` is 1, and `bus_req`, `bus_busy`, `addr_slot`, `data_beat` and `done` are all 0. `phase` is 0.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when `phase` is 0 and no completion is showing, so `req_valid` has no effect while a transaction runs. The codes for `req_op` are 0 for single read, 1 for single write, 2 for block read, 3 for copy-back and 4 for invalidate.
- R3: From the cycle after a request is taken, `bus_req` is high and `phase` is 1 (arbitration). Arbitration ends on the first edge at which `bus_gnt` is high, so a grant withheld for N edges gives N+1 arbitration cycles.
- R4: The address phase (`phase` 2) lasts exactly 4 cycles. `addr_slot` is high only in the first of them.
- R5: A single read or single write has one data beat lasting 2 counted cycles.
- R6: A block read has 4 beats: a first access of 2 cycles, then 3 burst beats of 2 cycles each, for 8 counted data cycles.
- R7: A copy-back has 4 beats, each a full memory access of 2 cycles, for 8 counted data cycles.
- R8: An invalidate goes straight from the address phase to completion, with no data-phase cycle and no `data_beat`.
- R9: A data-phase cycle with `slv_ready` low does not count. Each such cycle lengthens the data phase by one, and `data_beat` pulses only on a cycle with `slv_ready` high.
- R10: `bus_busy` is high from the first address cycle through the last data cycle, or through the last address cycle for an invalidate. In the following cycle `done` pulses for one cycle with `done_op` equal to the operation, while `bus_req` and `bus_busy` are both low. The block is ready again on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered by the cache controller |
| req_ready | output | 1 | Sequencer can take a request |
| req_op | input | 3 | Operation code of the offered request |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_busy | output | 1 | This master owns the bus this cycle |
| addr_slot | output | 1 | Address is driven on the bus this cycle |
| slv_ready | input | 1 | Slave completes the current data cycle |
| data_beat | output | 1 | A data beat finishes this cycle |
| done | output | 1 | Transaction complete, one-cycle pulse |
| done_op | output | 3 | Operation code of the completed transaction |
| phase | output | 2 | 0 idle/complete, 1 arbitration, 2 address, 3 data |

## Verification
The bench holds the grant back for different numbers of edges. A design that samples the grant one cycle late, or moves on before the grant arrives, shows up as a wrong arbitration cycle count. It stalls the slave inside data phases. A sequencer that counts stalled cycles, or that closes a beat without the slave, gives a data phase that is too short and ends its beats at the wrong times. The bench compares block read, copy-back and invalidate. A mix-up between burst and full-access timing, a missing beat, or a stray data phase on an invalidate each change the beat and busy counts. Finally it keeps a second request valid during a whole transaction. A design that takes that request would show a second bus request after completion, or report the wrong operation code.

// File: rtl/bus_txn_pkg.sv
package bus_txn_pkg;

  typedef enum logic [2:0] {
    OP_RD  = 3'd0,
    OP_WR  = 3'd1,
    OP_BRD = 3'd2,
    OP_CPB = 3'd3,
    OP_INV = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARB,
    S_ADDR,
    S_DATA,
    S_DONE
  } st_e;

  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_ARB  = 2'd1;
  localparam logic [1:0] PH_ADDR = 2'd2;
  localparam logic [1:0] PH_DATA = 2'd3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/txn_plan.sv
module txn_plan
  import bus_txn_pkg::*;
#(
  parameter int FIRST_CYC   = 2,
  parameter int BURST_CYC   = 2,
  parameter int BLOCK_BEATS = 4,
  parameter int CB_ACCESSES = 4,
  parameter int CW          = 3,
  parameter int BW          = 3
) (
  input  logic [2:0]    op_i,
  output logic [BW-1:0] beats_o,
  output logic [CW-1:0] first_len_o,
  output logic [CW-1:0] next_len_o,
  output logic          has_data_o
);

  always_comb begin
    beats_o     = BW'(1);
    first_len_o = CW'(FIRST_CYC);
    next_len_o  = CW'(FIRST_CYC);
    has_data_o  = 1'b1;
    case (op_i)
      OP_RD, OP_WR: begin
        beats_o = BW'(1);
      end
      OP_BRD: begin
        beats_o    = BW'(BLOCK_BEATS);
        next_len_o = CW'(BURST_CYC);
      end
      OP_CPB: begin
        beats_o = BW'(CB_ACCESSES);
      end
      default: begin
        beats_o    = '0;
        has_data_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/phase_cnt.sv
module phase_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/bus_txn_seq.sv
module bus_txn_seq
  import bus_txn_pkg::*;
#(
  parameter int ADDR_SLOT_CYC = 1,
  parameter int DECODE_CYC    = 3,
  parameter int FIRST_CYC     = 2,
  parameter int BURST_CYC     = 2,
  parameter int BLOCK_BEATS   = 4,
  parameter int CB_ACCESSES   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_op,
  output logic       bus_req,
  input  logic       bus_gnt,
  output logic       bus_busy,
  output logic       addr_slot,
  input  logic       slv_ready,
  output logic       data_beat,
  output logic       done,
  output logic [2:0] done_op,
  output logic [1:0] phase
);

  localparam int ADDR_CYC = ADDR_SLOT_CYC + DECODE_CYC;
  localparam int MAXC     = max3(ADDR_CYC, FIRST_CYC, BURST_CYC);
  localparam int CW       = $clog2(MAXC + 1);
  localparam int MAXB     = (BLOCK_BEATS > CB_ACCESSES) ? BLOCK_BEATS : CB_ACCESSES;
  localparam int BW       = (MAXB < 2) ? 1 : $clog2(MAXB + 1);

  st_e        st_q, st_d;
  logic [2:0] op_q;

  logic [BW-1:0] beats;
  logic [CW-1:0] first_len, next_len;
  logic          has_data;

  logic          cyc_load, cyc_dec, cyc_zero;
  logic [CW-1:0] cyc_val, cyc_cnt;
  logic          beat_load, beat_dec, beat_zero;
  logic [BW-1:0] beat_val, beat_cnt;

  txn_plan #(
    .FIRST_CYC  (FIRST_CYC),
    .BURST_CYC  (BURST_CYC),
    .BLOCK_BEATS(BLOCK_BEATS),
    .CB_ACCESSES(CB_ACCESSES),
    .CW         (CW),
    .BW         (BW)
  ) u_plan (
    .op_i       (op_q),
    .beats_o    (beats),
    .first_len_o(first_len),
    .next_len_o (next_len),
    .has_data_o (has_data)
  );

  phase_cnt #(.W(CW)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cyc_load),
    .load_val(cyc_val),
    .dec     (cyc_dec),
    .cnt     (cyc_cnt),
    .zero    (cyc_zero)
  );

  phase_cnt #(.W(BW)) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (beat_load),
    .load_val(beat_val),
    .dec     (beat_dec),
    .cnt     (beat_cnt),
    .zero    (beat_zero)
  );

  // Sequencing of phases and the two down counters.
  always_comb begin
    st_d      = st_q;
    cyc_load  = 1'b0;
    cyc_val   = '0;
    cyc_dec   = 1'b0;
    beat_load = 1'b0;
    beat_val  = '0;
    beat_dec  = 1'b0;
    data_beat = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req_valid) st_d = S_ARB;
      end
      S_ARB: begin
        if (bus_gnt) begin
          st_d     = S_ADDR;
          cyc_load = 1'b1;
          cyc_val  = CW'(ADDR_CYC - 1);
        end
      end
      S_ADDR: begin
        if (cyc_zero) begin
          if (has_data) begin
            st_d      = S_DATA;
            cyc_load  = 1'b1;
            cyc_val   = first_len - CW'(1);
            beat_load = 1'b1;
            beat_val  = beats - BW'(1);
          end else begin
            st_d = S_DONE;
          end
        end else begin
          cyc_dec = 1'b1;
        end
      end
      S_DATA: begin
        if (slv_ready) begin
          if (cyc_zero) begin
            data_beat = 1'b1;
            if (beat_zero) begin
              st_d = S_DONE;
            end else begin
              beat_dec = 1'b1;
              cyc_load = 1'b1;
              cyc_val  = next_len - CW'(1);
            end
          end else begin
            cyc_dec = 1'b1;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      op_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && req_valid) op_q <= req_op;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign bus_req   = (st_q == S_ARB) || (st_q == S_ADDR) || (st_q == S_DATA);
  assign bus_busy  = (st_q == S_ADDR) || (st_q == S_DATA);
  assign addr_slot = (st_q == S_ADDR) && (cyc_cnt >= CW'(DECODE_CYC));
  assign done      = (st_q == S_DONE);
  assign done_op   = op_q;

  always_comb begin
    case (st_q)
      S_ARB:   phase = PH_ARB;
      S_ADDR:  phase = PH_ADDR;
      S_DATA:  phase = PH_DATA;
      default: phase = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/bus_txn_seq_chk.sv
module bus_txn_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_busy,
  input logic       addr_slot,
  input logic       slv_ready,
  input logic       data_beat,
  input logic       done,
  input logic [1:0] phase
);

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (phase == 2'd0 && !bus_req && !done));

  assert_busy_after_gnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(bus_gnt));

  assert_slot_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_slot |=> !addr_slot);

  assert_slot_in_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_slot |-> (bus_busy && phase == 2'd2));

  assert_beat_needs_slave_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_beat |-> (slv_ready && phase == 2'd3));

  assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_req && !bus_busy));

  assert_busy_has_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> bus_req);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  assert_busy_end_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> done);

endmodule

bind bus_txn_seq bus_txn_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .bus_busy (bus_busy),
  .addr_slot(addr_slot),
  .slv_ready(slv_ready),
  .data_beat(data_beat),
  .done     (done),
  .phase    (phase)
);

// File: tb/bus_txn_seq_bench.sv
module bus_txn_seq_bench;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_op = 3'd0;
  logic       bus_req;
  logic       bus_gnt;
  logic       bus_busy;
  logic       addr_slot;
  logic       slv_ready;
  logic       data_beat;
  logic       done;
  logic [2:0] done_op;
  logic [1:0] phase;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int gnt_wait = 0;
  int stall = 0;
  logic arb_s = 1'b0;
  logic data_s = 1'b0;

  int n_arb, n_addr, n_slot, n_data, n_beat, n_busy, n_req, n_done, n_viol;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_txn_seq u_bus_txn_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_op   (req_op),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_busy (bus_busy),
    .addr_slot(addr_slot),
    .slv_ready(slv_ready),
    .data_beat(data_beat),
    .done     (done),
    .done_op  (done_op),
    .phase    (phase)
  );

  // Arbiter and slave models: counts drop on edges seen in the matching phase.
  assign bus_gnt   = (gnt_wait == 0);
  assign slv_ready = (stall == 0);

  always @(posedge clk) begin
    if (arb_s && gnt_wait > 0) gnt_wait <= gnt_wait - 1;
    if (data_s && stall > 0)   stall <= stall - 1;
  end

  always @(negedge clk) begin
    arb_s  = (phase == 2'd1);
    data_s = (phase == 2'd3);
    if (phase == 2'd1) n_arb++;
    if (phase == 2'd2) n_addr++;
    if (phase == 2'd3) n_data++;
    if (addr_slot) n_slot++;
    if (data_beat) n_beat++;
    if (bus_busy) n_busy++;
    if (bus_req) n_req++;
    if (done) n_done++;
    if (req_ready && phase != 2'd0) n_viol++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_arb = 0; n_addr = 0; n_slot = 0; n_data = 0; n_beat = 0;
    n_busy = 0; n_req = 0; n_done = 0; n_viol = 0;
  endtask

  function automatic int exp_data(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return 2;
      3'd2:       return 2 + 3 * 2;
      3'd3:       return 4 * 2;
      default:    return 0;
    endcase
  endfunction

  function automatic int exp_beats(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return 1;
      3'd2, 3'd3: return 4;
      default:    return 0;
    endcase
  endfunction

  task automatic issue(input logic [2:0] op);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 500 && !done; i++) @(negedge clk);
  endtask

  task automatic check_counts(input string req, input logic [2:0] op, input int g, input int s);
    int dc;
    dc = exp_data(op) + ((exp_data(op) > 0) ? s : 0);
    chk("R3", {req, " arbitration cycles"}, n_arb, g + 1);
    chk("R4", {req, " address cycles"}, n_addr, 4);
    chk("R4", {req, " address slot cycles"}, n_slot, 1);
    chk(req, "data cycles", n_data, dc);
    chk(req, "beats", n_beat, exp_beats(op));
    chk("R10", {req, " busy cycles"}, n_busy, 4 + dc);
    chk("R3", {req, " request cycles"}, n_req, g + 1 + 4 + dc);
    chk("R10", {req, " done pulses"}, n_done, 1);
  endtask

  task automatic run_txn(input string req, input logic [2:0] op, input int g, input int s);
    clear_counts();
    gnt_wait = g;
    stall = s;
    issue(op);
    wait_done();
    chk("R10", {req, " done seen"}, int'(done), 1);
    chk("R10", {req, " done_op"}, int'(done_op), int'(op));
    chk("R10", {req, " busy low at done"}, int'(bus_busy), 0);
    chk("R10", {req, " request low at done"}, int'(bus_req), 0);
    @(negedge clk);
    chk("R10", {req, " ready after done"}, int'(req_ready), 1);
    chk("R2", {req, " ready only when idle"}, n_viol, 0);
    check_counts(req, op, g, s);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1", "req_ready in reset", int'(req_ready), 1);
    chk("R1", "bus_req in reset", int'(bus_req), 0);
    chk("R1", "bus_busy in reset", int'(bus_busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "phase in reset", int'(phase), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready after reset", int'(req_ready), 1);
    chk("R1", "addr_slot after reset", int'(addr_slot), 0);
    chk("R1", "data_beat after reset", int'(data_beat), 0);
  endtask

  task automatic test_single_read();  run_txn("R5", 3'd0, 0, 0); endtask
  task automatic test_single_write(); run_txn("R5", 3'd1, 3, 0); endtask
  task automatic test_stall_write();  run_txn("R9", 3'd1, 0, 2); endtask
  task automatic test_block_read();   run_txn("R6", 3'd2, 1, 1); endtask
  task automatic test_copy_back();    run_txn("R7", 3'd3, 0, 3); endtask
  task automatic test_invalidate();   run_txn("R8", 3'd4, 2, 0); endtask

  task automatic test_reject_busy();
    clear_counts();
    gnt_wait = 1;
    stall = 0;
    issue(3'd2);
    req_op = 3'd1;
    req_valid = 1'b1;
    wait_done();
    req_valid = 1'b0;
    chk("R2", "op kept while busy", int'(done_op), 2);
    chk("R2", "beats of held request", n_beat, 4);
    chk("R2", "ready low while busy", n_viol, 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R2", "no second request", int'(bus_req), 0);
    chk("R2", "idle after reject", int'(phase), 0);
    chk("R2", "single completion", n_done, 1);
  endtask

  initial begin
    clear_counts();
    test_reset();
    test_single_read();
    test_single_write();
    test_stall_write();
    test_block_read();
    test_copy_back();
    test_invalidate();
    test_reject_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule